// File: doc/BRIEF.md
# End-of-Interrupt Vector Matcher

This block takes end-of-interrupt notices for an interrupt router and works out which router pins they apply to. Each notice carries an 8-bit vector and a flag that says whether the notice is level-mode. The block holds a small per-pin entry table with a vector and a mask bit for each pin, plus the remote-IRR status bit for each pin. The delivery path sets remote-IRR; a level-mode notice clears it.

A registered presence map has one bit per possible vector. It is rebuilt from the entry table after each table write. A notice whose vector has no bit set in the map is accepted and dropped in the same cycle, with no scan. A notice for a known vector starts a walk over all pins in ascending order, one pin per clock. Each pin whose entry vector equals the notice vector produces an acknowledge pulse that carries the pin index. For a level-mode notice, a retire cycle follows that acknowledge. The retire cycle clears the pin's remote-IRR. If the pin is unmasked and its request input is high, the same cycle raises a re-delivery request for the pin.

The control is a three-state machine:

- SCAN_IDLE: ready for a notice.
- SCAN_WALK: compares one pin.
- SCAN_RETIRE: handles the status update for a level-mode match.

Its transitions are:

- accept-known: SCAN_IDLE to SCAN_WALK.
- drop-unknown: stay in SCAN_IDLE.
- hit-level: SCAN_WALK to SCAN_RETIRE.
- advance: SCAN_WALK to SCAN_WALK, or SCAN_RETIRE to SCAN_WALK.
- finish: from the last pin back to SCAN_IDLE.

Top module: `eoi_vector_matcher`

## Requirements
- R1: After reset, eoi_ready is 1, and busy, ack_valid and redeliver_valid are 0. remote_irr is all zeros. Every entry holds vector 0 and is masked (mask bit 1 = masked).
- R2: A notice accepted while the presence map has no bit for its vector has no effect. busy stays 0, no acknowledge or re-delivery is produced, and remote_irr is unchanged. The map reflects a table write for notices accepted two or more clocks after the write edge.
- R3: For a known vector, every pin whose entry vector equals it gets exactly one acknowledge, in ascending pin order. busy stays high for NUM_PINS clocks, plus one clock for each match when the notice is level-mode.
- R4: A notice with eoi_level = 0 produces only acknowledges. It produces no re-delivery and leaves remote_irr unchanged.
- R5: A notice with eoi_level = 1 clears remote_irr of each matching pin. The clear happens in the clock after that pin's acknowledge.
- R6: In that retire clock, redeliver_valid is 1 with redeliver_pin equal to the pin, if and only if the pin is unmasked and its pin_request bit is 1.
- R7: While a scan runs, eoi_ready is 0. A notice held valid meanwhile is accepted when the scan ends, and is not lost.
- R8: A table write to a pin below NUM_PINS replaces the pin's vector and mask and clears its remote_irr. A write to a pin index of NUM_PINS or above changes nothing.
- R9: A 1 on rirr_set sets that pin's remote_irr on the next edge. A table write to the same pin in the same cycle wins and clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_wr_en | input | 1 | Entry table write strobe |
| tbl_wr_pin | input | PIN_W | Pin index to write |
| tbl_wr_vector | input | VEC_W | New vector for the entry |
| tbl_wr_mask | input | 1 | New mask bit, 1 = masked |
| pin_request | input | NUM_PINS | Current request level of each pin |
| rirr_set | input | NUM_PINS | Sets remote-IRR per pin (from the delivery path) |
| eoi_valid | input | 1 | A notice is offered |
| eoi_ready | output | 1 | Notice accepted on this edge when valid |
| eoi_vector | input | VEC_W | Notice vector |
| eoi_level | input | 1 | 1 = level-mode notice |
| busy | output | 1 | Scan in progress |
| ack_valid | output | 1 | Acknowledge pulse for a matching pin |
| ack_pin | output | PIN_W | Pin being acknowledged |
| redeliver_valid | output | 1 | Re-delivery request |
| redeliver_pin | output | PIN_W | Pin to re-deliver |
| remote_irr | output | NUM_PINS | Remote-IRR status per pin |

## Verification
The assertions assume the following about the inputs:

- The entry table is written only while no scan is running.
- The delivery path never pulses rirr_set for a pin in the cycle that pin is retired.

Under those conditions, a re-delivery and the remote-IRR clear can be tied to the acknowledge that comes just before them. The stimulus issues table writes and rirr_set pulses only between notices, with the block idle. The one deliberate overlap of a write and a set on the same pin also happens while idle. Notices are offered only at the falling edge. Back-to-back traffic is produced by holding a second notice valid through a running scan.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

    // Scan controller states
    typedef enum logic [1:0] {
        SCAN_IDLE   = 2'd0,
        SCAN_WALK   = 2'd1,
        SCAN_RETIRE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/eoi_entry_table.sv
// Per-pin entry storage: vector, mask and remote-IRR status.
module eoi_entry_table #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int PIN_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [PIN_W-1:0]          wr_pin,
    input  logic [VEC_W-1:0]          wr_vector,
    input  logic                      wr_mask,
    input  logic [NUM_PINS-1:0]       rirr_set,
    input  logic                      clr_en,
    input  logic [PIN_W-1:0]          clr_pin,
    output logic [NUM_PINS*VEC_W-1:0] vec_flat,
    output logic [NUM_PINS-1:0]       mask_o,
    output logic [NUM_PINS-1:0]       rirr_o,
    output logic                      wr_seen
);

    always_ff @(posedge clk) begin
        if (!rst_n) wr_seen <= 1'b0;
        else        wr_seen <= wr_en;
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        localparam logic [PIN_W-1:0] IDX = PIN_W'(g);
        logic sel_wr;
        logic sel_clr;
        assign sel_wr  = wr_en  && (wr_pin  == IDX);
        assign sel_clr = clr_en && (clr_pin == IDX);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vec_flat[g*VEC_W +: VEC_W] <= '0;
                mask_o[g]                  <= 1'b1;
            end else if (sel_wr) begin
                vec_flat[g*VEC_W +: VEC_W] <= wr_vector;
                mask_o[g]                  <= wr_mask;
            end
        end

        // write clears, then delivery set, then retire clear
        always_ff @(posedge clk) begin
            if (!rst_n)           rirr_o[g] <= 1'b0;
            else if (sel_wr)      rirr_o[g] <= 1'b0;
            else if (rirr_set[g]) rirr_o[g] <= 1'b1;
            else if (sel_clr)     rirr_o[g] <= 1'b0;
        end
    end

endmodule

// File: rtl/eoi_vec_presence.sv
// One bit per vector, set when any entry carries that vector.
module eoi_vec_presence #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int NUM_VEC  = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rebuild,
    input  logic [NUM_PINS*VEC_W-1:0] vec_flat,
    output logic [NUM_VEC-1:0]        present
);

    // every entry resets to vector 0
    localparam logic [NUM_VEC-1:0] RESET_MAP = {{(NUM_VEC-1){1'b0}}, 1'b1};

    logic [NUM_VEC-1:0] map_d;

    always_comb begin
        map_d = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            map_d[vec_flat[p*VEC_W +: VEC_W]] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       present <= RESET_MAP;
        else if (rebuild) present <= map_d;
    end

endmodule

// File: rtl/eoi_scan_fsm.sv
// Walks pins in ascending order for one accepted notice.
module eoi_scan_fsm
    import eoi_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int PIN_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eoi_valid,
    input  logic [VEC_W-1:0] eoi_vector,
    input  logic             eoi_level,
    input  logic             vec_known,
    input  logic [VEC_W-1:0] cur_vec,
    input  logic             cur_mask,
    input  logic             cur_req,
    output logic             eoi_ready,
    output logic             busy,
    output logic [PIN_W-1:0] idx,
    output logic             ack_valid,
    output logic             redeliver_valid,
    output logic             clr_en
);

    localparam logic [PIN_W-1:0] LAST_PIN = PIN_W'(NUM_PINS - 1);

    scan_state_e      state_q, state_d;
    logic [PIN_W-1:0] idx_q;
    logic [VEC_W-1:0] vec_q;
    logic             lvl_q;
    logic             hit;
    logic             at_last;

    assign hit     = (cur_vec == vec_q);
    assign at_last = (idx_q == LAST_PIN);
    assign idx     = idx_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCAN_IDLE:   if (eoi_valid && vec_known) state_d = SCAN_WALK;
            SCAN_WALK: begin
                if (hit && lvl_q)  state_d = SCAN_RETIRE;
                else if (at_last)  state_d = SCAN_IDLE;
                else               state_d = SCAN_WALK;
            end
            SCAN_RETIRE: state_d = at_last ? SCAN_IDLE : SCAN_WALK;
            default:     state_d = SCAN_IDLE;
        endcase
    end

    // state register and scan context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SCAN_IDLE;
            idx_q   <= '0;
            vec_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                SCAN_IDLE: begin
                    if (eoi_valid) begin
                        idx_q <= '0;
                        vec_q <= eoi_vector;
                        lvl_q <= eoi_level;
                    end
                end
                SCAN_WALK: begin
                    if (!(hit && lvl_q) && !at_last) idx_q <= idx_q + PIN_W'(1);
                end
                SCAN_RETIRE: begin
                    if (!at_last) idx_q <= idx_q + PIN_W'(1);
                end
                default: idx_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        eoi_ready       = 1'b0;
        busy            = 1'b0;
        ack_valid       = 1'b0;
        redeliver_valid = 1'b0;
        clr_en          = 1'b0;
        unique case (state_q)
            SCAN_IDLE:   eoi_ready = 1'b1;
            SCAN_WALK: begin
                busy      = 1'b1;
                ack_valid = hit;
            end
            SCAN_RETIRE: begin
                busy            = 1'b1;
                clr_en          = 1'b1;
                redeliver_valid = !cur_mask && cur_req;
            end
            default: eoi_ready = 1'b0;
        endcase
    end

endmodule

// File: rtl/eoi_vector_matcher.sv
module eoi_vector_matcher #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int PIN_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tbl_wr_en,
    input  logic [PIN_W-1:0]    tbl_wr_pin,
    input  logic [VEC_W-1:0]    tbl_wr_vector,
    input  logic                tbl_wr_mask,
    input  logic [NUM_PINS-1:0] pin_request,
    input  logic [NUM_PINS-1:0] rirr_set,
    input  logic                eoi_valid,
    output logic                eoi_ready,
    input  logic [VEC_W-1:0]    eoi_vector,
    input  logic                eoi_level,
    output logic                busy,
    output logic                ack_valid,
    output logic [PIN_W-1:0]    ack_pin,
    output logic                redeliver_valid,
    output logic [PIN_W-1:0]    redeliver_pin,
    output logic [NUM_PINS-1:0] remote_irr
);

    localparam int NUM_VEC = 1 << VEC_W;

    logic [NUM_PINS*VEC_W-1:0] vec_flat;
    logic [NUM_PINS-1:0]       mask_bits;
    logic                      wr_seen;
    logic [NUM_VEC-1:0]        vec_present;
    logic [PIN_W-1:0]          scan_idx;
    logic                      clr_en;
    logic [VEC_W-1:0]          cur_vec;
    logic                      cur_mask;
    logic                      cur_req;

    eoi_entry_table #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W),
        .PIN_W    (PIN_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_wr_en),
        .wr_pin    (tbl_wr_pin),
        .wr_vector (tbl_wr_vector),
        .wr_mask   (tbl_wr_mask),
        .rirr_set  (rirr_set),
        .clr_en    (clr_en),
        .clr_pin   (scan_idx),
        .vec_flat  (vec_flat),
        .mask_o    (mask_bits),
        .rirr_o    (remote_irr),
        .wr_seen   (wr_seen)
    );

    eoi_vec_presence #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W),
        .NUM_VEC  (NUM_VEC)
    ) u_presence (
        .clk      (clk),
        .rst_n    (rst_n),
        .rebuild  (wr_seen),
        .vec_flat (vec_flat),
        .present  (vec_present)
    );

    // entry selected by the scan index
    always_comb begin
        cur_vec  = '0;
        cur_mask = 1'b1;
        cur_req  = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (scan_idx == PIN_W'(p)) begin
                cur_vec  = vec_flat[p*VEC_W +: VEC_W];
                cur_mask = mask_bits[p];
                cur_req  = pin_request[p];
            end
        end
    end

    eoi_scan_fsm #(
        .NUM_PINS (NUM_PINS),
        .VEC_W    (VEC_W),
        .PIN_W    (PIN_W)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .eoi_valid       (eoi_valid),
        .eoi_vector      (eoi_vector),
        .eoi_level       (eoi_level),
        .vec_known       (vec_present[eoi_vector]),
        .cur_vec         (cur_vec),
        .cur_mask        (cur_mask),
        .cur_req         (cur_req),
        .eoi_ready       (eoi_ready),
        .busy            (busy),
        .idx             (scan_idx),
        .ack_valid       (ack_valid),
        .redeliver_valid (redeliver_valid),
        .clr_en          (clr_en)
    );

    assign ack_pin       = scan_idx;
    assign redeliver_pin = scan_idx;

endmodule

// File: rtl/eoi_vector_matcher_chk.sv
module eoi_vector_matcher_chk #(
    parameter int NUM_PINS = 24,
    parameter int VEC_W    = 8,
    parameter int PIN_W    = 5,
    parameter int NUM_VEC  = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                tbl_wr_en,
    input logic [NUM_PINS-1:0] rirr_set,
    input logic                eoi_valid,
    input logic                eoi_ready,
    input logic [VEC_W-1:0]    eoi_vector,
    input logic                busy,
    input logic                ack_valid,
    input logic [PIN_W-1:0]    ack_pin,
    input logic                redeliver_valid,
    input logic [PIN_W-1:0]    redeliver_pin,
    input logic [NUM_PINS-1:0] remote_irr,
    input logic [NUM_VEC-1:0]  vec_present
);

    // R3
    ack_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (busy && (ack_pin < PIN_W'(NUM_PINS))));

    // R3
    ack_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && $past(ack_valid) && $past(busy)) |-> (ack_pin > $past(ack_pin)));

    // R6
    redeliver_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redeliver_valid |-> ($past(ack_valid) && ($past(ack_pin) == redeliver_pin)));

    // R5
    rirr_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redeliver_valid && !rirr_set[redeliver_pin] && !tbl_wr_en)
            |=> !remote_irr[$past(redeliver_pin)]);

    // R2
    unknown_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && eoi_ready && !vec_present[eoi_vector]) |=> !busy);

    // R7
    held_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && busy) |-> !eoi_ready);

endmodule

bind eoi_vector_matcher eoi_vector_matcher_chk #(
    .NUM_PINS (NUM_PINS),
    .VEC_W    (VEC_W),
    .PIN_W    (PIN_W),
    .NUM_VEC  (NUM_VEC)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tbl_wr_en       (tbl_wr_en),
    .rirr_set        (rirr_set),
    .eoi_valid       (eoi_valid),
    .eoi_ready       (eoi_ready),
    .eoi_vector      (eoi_vector),
    .busy            (busy),
    .ack_valid       (ack_valid),
    .ack_pin         (ack_pin),
    .redeliver_valid (redeliver_valid),
    .redeliver_pin   (redeliver_pin),
    .remote_irr      (remote_irr),
    .vec_present     (vec_present)
);

// File: tb/eoi_vector_matcher_tb.sv
`timescale 1ns/1ps
module eoi_vector_matcher_tb;

    localparam int NP = 24;
    localparam int VW = 8;
    localparam int PW = 5;
    localparam logic [NP-1:0] ALL1 = {NP{1'b1}};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tbl_wr_en;
    logic [PW-1:0] tbl_wr_pin;
    logic [VW-1:0] tbl_wr_vector;
    logic          tbl_wr_mask;
    logic [NP-1:0] pin_request;
    logic [NP-1:0] rirr_set;
    logic          eoi_valid;
    logic          eoi_ready;
    logic [VW-1:0] eoi_vector;
    logic          eoi_level;
    logic          busy;
    logic          ack_valid;
    logic [PW-1:0] ack_pin;
    logic          redeliver_valid;
    logic [PW-1:0] redeliver_pin;
    logic [NP-1:0] remote_irr;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    eoi_vector_matcher u_dut (
        .clk(clk), .rst_n(rst_n),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_pin(tbl_wr_pin),
        .tbl_wr_vector(tbl_wr_vector), .tbl_wr_mask(tbl_wr_mask),
        .pin_request(pin_request), .rirr_set(rirr_set),
        .eoi_valid(eoi_valid), .eoi_ready(eoi_ready),
        .eoi_vector(eoi_vector), .eoi_level(eoi_level),
        .busy(busy), .ack_valid(ack_valid), .ack_pin(ack_pin),
        .redeliver_valid(redeliver_valid), .redeliver_pin(redeliver_pin),
        .remote_irr(remote_irr)
    );

    // row: vector[80:73] level[72] request[71:48] expected ack[47:24] expected redeliver[23:0]
    localparam int NROWS = 8;
    localparam logic [80:0] ROWS [NROWS] = '{
        {8'h41, 1'b1, 24'h800024, 24'h800224, 24'h800004},
        {8'h41, 1'b0, 24'hFFFFFF, 24'h800224, 24'h000000},
        {8'h41, 1'b1, 24'h000000, 24'h800224, 24'h000000},
        {8'h55, 1'b1, 24'hFFFFFF, 24'h000000, 24'h000000},
        {8'h90, 1'b1, 24'h001000, 24'h001000, 24'h001000},
        {8'h80, 1'b1, 24'h000080, 24'h000080, 24'h000080},
        {8'h00, 1'b0, 24'hFFFFFF, 24'h7FED5B, 24'h000000},
        {8'h00, 1'b1, 24'hFFFFFF, 24'h7FED5B, 24'h000000}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic prog(input int pin, input logic [VW-1:0] v, input logic m);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_pin = PW'(pin); tbl_wr_vector = v; tbl_wr_mask = m;
        @(negedge clk);
        tbl_wr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic set_all_rirr();
        @(negedge clk);
        rirr_set = ALL1;
        @(negedge clk);
        rirr_set = '0;
        @(negedge clk);
        chk(remote_irr == ALL1, "R9", "remote_irr after set pulse", remote_irr, ALL1);
    endtask

    task automatic run_notice(input logic [VW-1:0] v, input logic lv,
                              input logic [NP-1:0] req,
                              input logic [NP-1:0] exp_ack,
                              input logic [NP-1:0] exp_redel);
        logic [NP-1:0] got_ack;
        logic [NP-1:0] got_redel;
        logic [NP-1:0] rirr_before;
        logic [NP-1:0] exp_rirr;
        int busy_cyc;
        int last;
        int exp_busy;
        pin_request = req;
        rirr_before = remote_irr;
        got_ack = '0; got_redel = '0; busy_cyc = 0; last = -1;
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v; eoi_level = lv;
        @(negedge clk);
        eoi_valid = 1'b0;
        for (int c = 0; c < 2*NP + 4; c++) begin
            if (busy) busy_cyc++;
            if (ack_valid) begin
                // R3 ascending order
                chk(int'(ack_pin) > last, "R3", "ack order", ack_pin, last + 1);
                last = int'(ack_pin);
                got_ack[ack_pin] = 1'b1;
            end
            if (redeliver_valid) begin
                // R6 same pin as the preceding ack
                chk(int'(redeliver_pin) == last, "R6", "redeliver pin", redeliver_pin, last);
                got_redel[redeliver_pin] = 1'b1;
            end
            @(negedge clk);
        end
        exp_busy = (exp_ack == '0) ? 0 : NP + (lv ? $countones(exp_ack) : 0);
        exp_rirr = lv ? (rirr_before & ~exp_ack) : rirr_before;
        chk(got_ack == exp_ack, (exp_ack == '0) ? "R2" : "R3", "ack set", got_ack, exp_ack);
        chk(got_redel == exp_redel, lv ? "R6" : "R4", "redeliver set", got_redel, exp_redel);
        chk(busy_cyc == exp_busy, (exp_ack == '0) ? "R2" : "R3", "busy cycles", busy_cyc, exp_busy);
        chk(remote_irr == exp_rirr, lv ? "R5" : "R4", "remote_irr after notice", remote_irr, exp_rirr);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tbl_wr_en = 1'b0; tbl_wr_pin = '0; tbl_wr_vector = '0;
        tbl_wr_mask = 1'b0; pin_request = '0; rirr_set = '0;
        eoi_valid = 1'b0; eoi_vector = '0; eoi_level = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(eoi_ready == 1'b1, "R1", "eoi_ready", eoi_ready, 1);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(ack_valid == 1'b0, "R1", "ack_valid", ack_valid, 0);
        chk(redeliver_valid == 1'b0, "R1", "redeliver_valid", redeliver_valid, 0);
        chk(remote_irr == '0, "R1", "remote_irr", remote_irr, 0);

        prog(2,  8'h41, 1'b0);
        prog(5,  8'h41, 1'b1);
        prog(9,  8'h41, 1'b0);
        prog(23, 8'h41, 1'b0);
        prog(7,  8'h80, 1'b0);
        prog(12, 8'h90, 1'b0);

        // table walk
        for (int r = 0; r < NROWS; r++) begin
            set_all_rirr();
            run_notice(ROWS[r][80:73], ROWS[r][72], ROWS[r][71:48],
                       ROWS[r][47:24], ROWS[r][23:0]);
        end

        // R8 out-of-range write changes nothing
        prog(30, 8'h66, 1'b0);
        run_notice(8'h66, 1'b1, ALL1, '0, '0);

        // R8 / R9 write and set on pin 12 in the same cycle
        @(negedge clk);
        rirr_set = ALL1;
        tbl_wr_en = 1'b1; tbl_wr_pin = PW'(12); tbl_wr_vector = 8'h91; tbl_wr_mask = 1'b0;
        @(negedge clk);
        rirr_set = '0; tbl_wr_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(remote_irr == (ALL1 & ~24'h001000), "R9", "write beats set",
            remote_irr, ALL1 & ~24'h001000);
        // R2 old vector removed from map; R8 new vector in effect
        run_notice(8'h90, 1'b1, ALL1, '0, '0);
        run_notice(8'h91, 1'b1, 24'h001000, 24'h001000, 24'h001000);

        // R7 second notice held during a scan
        begin
            int n_ack;
            logic [NP-1:0] u;
            bit acc;
            n_ack = 0; u = '0; acc = 0;
            @(negedge clk);
            eoi_valid = 1'b1; eoi_vector = 8'h41; eoi_level = 1'b0;
            @(negedge clk);
            eoi_vector = 8'h91;
            chk(eoi_ready == 1'b0, "R7", "ready during scan", eoi_ready, 0);
            for (int c = 0; c < 80; c++) begin
                if (ack_valid) begin n_ack++; u[ack_pin] = 1'b1; end
                if (eoi_valid && eoi_ready) acc = 1;
                @(negedge clk);
                if (acc) eoi_valid = 1'b0;
            end
            chk(acc == 1'b1, "R7", "held notice accepted", acc, 1);
            chk(n_ack == 5, "R7", "ack count over both notices", n_ack, 5);
            chk(u == 24'h801224, "R7", "acked pins over both notices", u, 24'h801224);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule